// File: doc/BRIEF.md
# Ethernet Receive Address Filter

The filter watches the header bytes of each received Ethernet frame and returns one verdict per frame: accept (pass it to the host) or drop. It decides from the destination address, the EtherType field and the CRC status reported with the last byte. It does not compute the CRC, buffer data or move frames anywhere. It only classifies them.

Software programs five registers through a plain write port. These are a 48-bit station address, a 48-bit multicast match address and a six-bit control word. Frame bytes arrive on a valid/ready byte stream with start and end markers. The verdict leaves on a valid/ready output. A verdict that has not been taken stalls the byte stream: `in_ready` is low exactly while `vrd_valid` is high and `vrd_ready` is low. Once `vrd_valid` rises it stays high with a constant `vrd_accept` until the cycle in which `vrd_ready` is high. Header bytes are never reordered or lost.

Top module: `rx_addr_filter`

## Requirements
- R1: Register writes use select codes 0 for station address bytes 0-1, 1 for station bytes 2-5, 2 for multicast bytes 0-1 and 3 for multicast bytes 2-5. Within each register the byte with the lowest index is in the most significant used bits: bytes 0-1 sit in bits 15:8 and 7:0, and bytes 2-5 sit in bits 31:24 down to 7:0. Select code 4 writes the control word from bits 5:0. Writes with any other code change nothing.
- R2: Control bit 0 turns on unicast matching. A unicast frame is accepted only if all six destination bytes equal the station address. With the bit clear, every unicast frame passes the address stage.
- R3: Control bit 1 turns on multicast matching. A multicast frame is accepted only if its destination equals the multicast address. A frame is multicast when bit 0 of destination byte 0 is 1 and the destination is not all ones.
- R4: Control bit 2 drops broadcast frames, meaning frames whose destination is all ones. With the bit clear, broadcast frames are accepted and are not subject to multicast matching.
- R5: Control bit 3 drops frames whose header bytes 12-13 are 0x81, 0x00 (a VLAN tag). Any other type value is unaffected.
- R6: A pause frame has destination 01-80-C2-00-00-01 and type bytes 0x88, 0x08. It is accepted when control bit 4 is set, whatever the address-match settings are, and dropped when the bit is clear.
- R7: A frame whose end byte carries the CRC-error flag is dropped unless control bit 5 is set.
- R8: A frame shorter than 14 bytes is dropped. A 14-byte frame is judged normally.
- R9: The verdict becomes valid in the cycle after the end byte is accepted, exactly once per frame. Beats received outside a frame (after an end and before the next start) produce no verdict.
- R10: While `vrd_valid` is high and `vrd_ready` is low, `vrd_valid` and `vrd_accept` hold and `in_ready` is low. Otherwise `in_ready` is high.
- R11: After reset `vrd_valid` is 0, `in_ready` is 1, and the control word and both addresses are zero.
- R12: The checks apply in this order of precedence: short frame, CRC error, pause, VLAN drop, then the address class (broadcast, multicast, unicast).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted when high with `in_valid` |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_crc_err | input | 1 | CRC error, sampled with the last byte |
| vrd_valid | output | 1 | Verdict valid |
| vrd_ready | input | 1 | Verdict consumer ready |
| vrd_accept | output | 1 | 1 = accept frame, 0 = drop |

## Verification
A corrupt byte counter or frame-active flag shows up at the verdict of the very frame it affects. The counter error turns a short frame into an accepted one or the reverse. The flag error adds a verdict for stray beats or suppresses a real one, one cycle after the end byte. A wrongly stored address byte or control bit shows only on a frame of the class that bit governs. For that reason every control bit is crossed with frames of its own class, with near-miss addresses and with neighbouring type values. A broken stall path shows as a verdict that changes or vanishes while `vrd_ready` is low, or as header bytes taken while it is held.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int ETH_HDR_BYTES = 14;
  localparam int DST_BYTES     = 6;
  localparam int TYPE_POS      = 12;

  localparam logic [15:0] TPID_VLAN  = 16'h8100;
  localparam logic [15:0] TYPE_PAUSE = 16'h8808;
  localparam logic [47:0] DST_PAUSE  = 48'h0180_C200_0001;

  typedef struct packed {
    logic crc_pass;
    logic pause_pass;
    logic vlan_drop;
    logic bc_drop;
    logic mc_en;
    logic uc_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [2:0] {
    SEL_STN_HI = 3'd0,
    SEL_STN_LO = 3'd1,
    SEL_MC_HI  = 3'd2,
    SEL_MC_LO  = 3'd3,
    SEL_CTRL   = 3'd4
  } reg_sel_e;

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [47:0]       station_addr,
  output logic [47:0]       mcast_addr,
  output ctrl_t             ctrl
);

  logic [15:0] stn_hi_q, mc_hi_q;
  logic [31:0] stn_lo_q, mc_lo_q;
  ctrl_t       ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stn_hi_q <= '0;
      stn_lo_q <= '0;
      mc_hi_q  <= '0;
      mc_lo_q  <= '0;
      ctrl_q   <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(sel))
        SEL_STN_HI: stn_hi_q <= wdata[15:0];
        SEL_STN_LO: stn_lo_q <= wdata[31:0];
        SEL_MC_HI:  mc_hi_q  <= wdata[15:0];
        SEL_MC_LO:  mc_lo_q  <= wdata[31:0];
        SEL_CTRL:   ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  assign station_addr = {stn_hi_q, stn_lo_q};
  assign mcast_addr   = {mc_hi_q, mc_lo_q};
  assign ctrl         = ctrl_q;

endmodule

// File: rtl/rxf_hdr_capture.sv
module rxf_hdr_capture
  import rxf_pkg::*;
#(
  parameter int HDR_BYTES = ETH_HDR_BYTES,
  localparam int CNT_W    = $clog2(HDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             eof,
  input  logic [7:0]       data,
  output logic [47:0]      dst_nxt,
  output logic [15:0]      etype_nxt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             frame_end
);

  logic [HDR_BYTES-1:0][7:0] hdr_q, hdr_nxt;
  logic [CNT_W-1:0]          cnt_q, cnt_base;
  logic                      in_frame_q, take;

  assign take     = beat && (sof || in_frame_q);
  assign cnt_base = sof ? '0 : cnt_q;

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_byte
    assign hdr_nxt[g] = (take && cnt_base == CNT_W'(g)) ? data : hdr_q[g];
  end

  always_comb begin
    cnt_nxt = cnt_q;
    if (take) begin
      if (cnt_base == CNT_W'(HDR_BYTES)) cnt_nxt = cnt_base;
      else                               cnt_nxt = cnt_base + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q      <= '0;
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
    end else begin
      hdr_q <= hdr_nxt;
      cnt_q <= cnt_nxt;
      if (take) in_frame_q <= !eof;
    end
  end

  for (genvar d = 0; d < DST_BYTES; d++) begin : g_dst
    assign dst_nxt[(DST_BYTES-1-d)*8 +: 8] = hdr_nxt[d];
  end

  assign etype_nxt = {hdr_nxt[TYPE_POS], hdr_nxt[TYPE_POS+1]};
  assign frame_end = take && eof;

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int HDR_BYTES = ETH_HDR_BYTES,
  localparam int CNT_W    = $clog2(HDR_BYTES + 1)
) (
  input  logic [47:0]      dst,
  input  logic [15:0]      etype,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             crc_err,
  input  ctrl_t            ctrl,
  input  logic [47:0]      station_addr,
  input  logic [47:0]      mcast_addr,
  output logic             accept
);

  logic is_short, is_bc, is_mc, is_vlan, is_pause;

  assign is_short = byte_cnt < CNT_W'(HDR_BYTES);
  assign is_bc    = &dst;
  assign is_mc    = dst[40] && !is_bc;
  assign is_vlan  = etype == TPID_VLAN;
  assign is_pause = (etype == TYPE_PAUSE) && (dst == DST_PAUSE);

  always_comb begin
    if (is_short)                      accept = 1'b0;
    else if (crc_err && !ctrl.crc_pass) accept = 1'b0;
    else if (is_pause)                 accept = ctrl.pause_pass;
    else if (is_vlan && ctrl.vlan_drop) accept = 1'b0;
    else if (is_bc)                    accept = !ctrl.bc_drop;
    else if (is_mc)                    accept = !ctrl.mc_en || (dst == mcast_addr);
    else                               accept = !ctrl.uc_en || (dst == station_addr);
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int HDR_BYTES = ETH_HDR_BYTES,
  parameter int CFG_W     = 32,
  localparam int CNT_W    = $clog2(HDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [2:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_crc_err,
  output logic             vrd_valid,
  input  logic             vrd_ready,
  output logic             vrd_accept
);

  logic [47:0]      station_addr, mcast_addr, dst_nxt;
  logic [15:0]      etype_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  ctrl_t            ctrl_q;
  logic             beat, frame_end, accept_nxt;
  logic             vrd_valid_q, vrd_accept_q;

  assign in_ready = !vrd_valid_q || vrd_ready;
  assign beat     = in_valid && in_ready;

  rxf_cfg_regs #(.DATA_W(CFG_W)) i_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_wr_en),
    .sel          (cfg_sel),
    .wdata        (cfg_wdata),
    .station_addr (station_addr),
    .mcast_addr   (mcast_addr),
    .ctrl         (ctrl_q)
  );

  rxf_hdr_capture #(.HDR_BYTES(HDR_BYTES)) i_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .sof       (in_sof),
    .eof       (in_eof),
    .data      (in_data),
    .dst_nxt   (dst_nxt),
    .etype_nxt (etype_nxt),
    .cnt_nxt   (cnt_nxt),
    .frame_end (frame_end)
  );

  rxf_decide #(.HDR_BYTES(HDR_BYTES)) i_decide (
    .dst          (dst_nxt),
    .etype        (etype_nxt),
    .byte_cnt     (cnt_nxt),
    .crc_err      (in_crc_err),
    .ctrl         (ctrl_q),
    .station_addr (station_addr),
    .mcast_addr   (mcast_addr),
    .accept       (accept_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vrd_valid_q  <= 1'b0;
      vrd_accept_q <= 1'b0;
    end else if (frame_end) begin
      vrd_valid_q  <= 1'b1;
      vrd_accept_q <= accept_nxt;
    end else if (vrd_ready) begin
      vrd_valid_q  <= 1'b0;
    end
  end

  assign vrd_valid  = vrd_valid_q;
  assign vrd_accept = vrd_accept_q;

endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk
  import rxf_pkg::*;
#(
  parameter int HDR_BYTES = ETH_HDR_BYTES,
  localparam int CNT_W    = $clog2(HDR_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_eof,
  input logic             in_crc_err,
  input logic             vrd_valid,
  input logic             vrd_ready,
  input logic             vrd_accept,
  input logic             end_beat,
  input logic [CNT_W-1:0] hdr_cnt,
  input ctrl_t            ctrl
);

  AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vrd_valid && !vrd_ready |=> vrd_valid && $stable(vrd_accept)); // R10

  AST_INPUT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    vrd_valid && !vrd_ready |-> !in_ready); // R10

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !vrd_valid |-> in_ready); // R10

  AST_VERDICT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vrd_valid) |-> $past(in_valid && in_ready && in_eof)); // R9

  AST_CRC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    end_beat && in_crc_err && !ctrl.crc_pass |=> vrd_valid && !vrd_accept); // R7

  AST_SHORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    end_beat && hdr_cnt < CNT_W'(HDR_BYTES) |=> vrd_valid && !vrd_accept); // R8

endmodule

bind rx_addr_filter rxf_filter_chk #(.HDR_BYTES(HDR_BYTES)) i_filter_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_eof     (in_eof),
  .in_crc_err (in_crc_err),
  .vrd_valid  (vrd_valid),
  .vrd_ready  (vrd_ready),
  .vrd_accept (vrd_accept),
  .end_beat   (frame_end),
  .hdr_cnt    (cnt_nxt),
  .ctrl       (ctrl_q)
);

// File: tb/test_rx_addr_filter.sv
`timescale 1ns/1ps
module test_rx_addr_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        in_crc_err = 1'b0;
  logic        vrd_valid;
  logic        vrd_ready = 1'b1;
  logic        vrd_accept;

  int n_chk = 0;
  int n_err = 0;

  localparam logic [47:0] STN   = 48'hAABB_CCDD_EE01;
  localparam logic [47:0] MCA   = 48'h0100_5E00_00FB;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] PDST  = 48'h0180_C200_0001;

  // control word bits: 0 uc_en, 1 mc_en, 2 bc_drop, 3 vlan_drop, 4 pause_pass, 5 crc_pass
  localparam logic [31:0] C_UC = 32'h01, C_MC = 32'h02, C_BC = 32'h04;
  localparam logic [31:0] C_VL = 32'h08, C_PA = 32'h10, C_CRC = 32'h20;

  always #5 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_crc_err(in_crc_err), .vrd_valid(vrd_valid), .vrd_ready(vrd_ready),
    .vrd_accept(vrd_accept)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] val);
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
  endtask

  function automatic logic [7:0] fbyte(input logic [47:0] dst, input logic [15:0] et, input int i);
    if (i < 6)       return dst[47-8*i -: 8];
    else if (i == 12) return et[15:8];
    else if (i == 13) return et[7:0];
    else              return 8'(8'h10 + i);
  endfunction

  task automatic send_frame(input logic [47:0] dst, input logic [15:0] et, input int len,
                            input bit crc, input bit exp, input string req);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = fbyte(dst, et, i);
      in_sof = (i == 0); in_eof = (i == len - 1); in_crc_err = crc && (i == len - 1);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_crc_err = 1'b0;
    @(negedge clk);
    check(vrd_valid == 1'b1, {req, " verdict valid after end"}, int'(vrd_valid), 1);
    check(vrd_accept == exp, {req, " verdict"}, int'(vrd_accept), int'(exp));
    if (vrd_ready) begin
      @(negedge clk);
      check(vrd_valid == 1'b0, "R9 single verdict per frame", int'(vrd_valid), 0);
    end
  endtask

  task automatic t_reset;
    check(vrd_valid == 1'b0, "R11 reset vrd_valid", int'(vrd_valid), 0);
    check(in_ready == 1'b1, "R11 reset in_ready", int'(in_ready), 1);
    // zero control: good frames pass, CRC-errored dropped, pause dropped
    send_frame(48'h0011_2233_4455, 16'h0800, 20, 0, 1, "R11 default accepts unicast");
    send_frame(48'h0011_2233_4455, 16'h0800, 20, 1, 0, "R11 default drops CRC error");
    send_frame(PDST, 16'h8808, 20, 0, 0, "R11 default drops pause");
  endtask

  task automatic t_regs_unicast;
    wr_reg(3'd0, 32'h0000_AABB);
    wr_reg(3'd1, 32'hCCDD_EE01);
    wr_reg(3'd4, C_UC);
    send_frame(STN, 16'h0800, 20, 0, 1, "R1 R2 station match");
    send_frame(48'hAABB_CCDD_EE02, 16'h0800, 20, 0, 0, "R2 last byte differs");
    send_frame(48'hA8BB_CCDD_EE01, 16'h0800, 20, 0, 0, "R1 R2 first byte differs");
    wr_reg(3'd7, 32'hFFFF_FFFF);  // unused code: no effect
    send_frame(BCAST, 16'h0800, 20, 0, 1, "R1 unused select leaves control");
    send_frame(48'hA8BB_CCDD_EE02, 16'h0800, 20, 0, 0, "R1 unused select keeps uc_en");
    wr_reg(3'd4, 32'h0);
    send_frame(48'hAABB_CCDD_EE02, 16'h0800, 20, 0, 1, "R2 matching disabled");
  endtask

  task automatic t_multicast;
    wr_reg(3'd2, 32'h0000_0100);
    wr_reg(3'd3, 32'h5E00_00FB);
    wr_reg(3'd4, C_MC | C_UC);
    send_frame(MCA, 16'h0800, 20, 0, 1, "R3 multicast match");
    send_frame(48'h0100_5E00_00FC, 16'h0800, 20, 0, 0, "R3 multicast mismatch");
    send_frame(BCAST, 16'h0800, 20, 0, 1, "R4 broadcast exempt from multicast match");
    wr_reg(3'd4, C_UC);
    send_frame(48'h0100_5E00_00FC, 16'h0800, 20, 0, 1, "R3 multicast matching off");
  endtask

  task automatic t_broadcast;
    wr_reg(3'd4, C_BC);
    send_frame(BCAST, 16'h0800, 20, 0, 0, "R4 broadcast dropped");
    send_frame(48'hFFFF_FFFF_FFFE, 16'h0800, 20, 0, 1, "R4 near-broadcast multicast kept");
    wr_reg(3'd4, 32'h0);
    send_frame(BCAST, 16'h0800, 20, 0, 1, "R4 broadcast accepted");
  endtask

  task automatic t_vlan;
    wr_reg(3'd4, C_VL);
    send_frame(48'h0011_2233_4455, 16'h8100, 20, 0, 0, "R5 tagged dropped");
    send_frame(48'h0011_2233_4455, 16'h8101, 20, 0, 1, "R5 other type kept");
    wr_reg(3'd4, 32'h0);
    send_frame(48'h0011_2233_4455, 16'h8100, 20, 0, 1, "R5 tagged kept when off");
  endtask

  task automatic t_pause;
    wr_reg(3'd4, C_PA | C_MC);
    send_frame(PDST, 16'h8808, 20, 0, 1, "R6 R12 pause passes despite multicast mismatch");
    send_frame(PDST, 16'h0800, 20, 0, 0, "R6 not pause, multicast mismatch");
    wr_reg(3'd4, C_MC);
    send_frame(PDST, 16'h8808, 20, 0, 0, "R6 pause dropped");
  endtask

  task automatic t_crc_short;
    wr_reg(3'd4, C_CRC);
    send_frame(48'h0011_2233_4455, 16'h0800, 20, 1, 1, "R7 CRC error passed");
    send_frame(48'h0011_2233_4455, 16'h0800, 13, 1, 0, "R8 R12 short beats CRC pass");
    wr_reg(3'd4, C_PA);
    send_frame(PDST, 16'h8808, 20, 1, 0, "R7 R12 CRC error beats pause pass");
    wr_reg(3'd4, 32'h0);
    send_frame(48'h0011_2233_4455, 16'h0800, 13, 0, 0, "R8 13 bytes dropped");
    send_frame(48'h0011_2233_4455, 16'h0800, 14, 0, 1, "R8 14 bytes accepted");
    send_frame(48'h0011_2233_4455, 16'h0800, 1, 0, 0, "R8 single byte frame");
  endtask

  task automatic t_stray_beat;
    @(posedge clk); #1;
    in_valid = 1'b1; in_eof = 1'b1; in_data = 8'h55;
    @(posedge clk); #1;
    in_valid = 1'b0; in_eof = 1'b0;
    @(negedge clk);
    check(vrd_valid == 1'b0, "R9 stray end beat gives no verdict", int'(vrd_valid), 0);
  endtask

  task automatic t_backpressure;
    wr_reg(3'd4, C_BC);
    vrd_ready = 1'b0;
    send_frame(BCAST, 16'h0800, 20, 0, 0, "R10 held frame");
    @(posedge clk); #1;
    in_valid = 1'b1; in_sof = 1'b1; in_data = 8'h00;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R10 input stalled", int'(in_ready), 0);
      check(vrd_valid == 1'b1 && vrd_accept == 1'b0, "R10 verdict held", int'({vrd_valid, vrd_accept}), 2);
    end
    in_valid = 1'b0; in_sof = 1'b0; vrd_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R10 ready follows consumer", int'(in_ready), 1);
    send_frame(48'h0011_2233_4455, 16'h0800, 16, 0, 1, "R10 next frame after release");
    wr_reg(3'd4, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R9 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs_unicast();
    t_multicast();
    t_broadcast();
    t_vlan();
    t_pause();
    t_crc_short();
    t_stray_beat();
    t_backpressure();
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule